// File: doc/BRIEF.md
# Word-Organized Static RAM with Three-State Data Port

This block is a small static RAM of eight 4-bit words, built as a signal-level model for use inside a larger design or test environment. All three controls are active low: a chip select (`cs_n`), an output enable (`oe_n`) and a write enable (`we_n`). A row decoder turns the address into one select line per word. Each word is captured by that line, gated with the internal write strobe. Reads are combinational: the addressed word reaches the data pins as soon as the controls allow it.

A parameter picks one of two port styles. In the split style, data arrives on `din` and leaves on a three-state `dout`. In the shared style, one bidirectional bus `dio` carries data in both directions. The internal drive enable needs chip select and output enable low, and it is also forced off whenever write enable is low. A write cycle therefore never has the RAM driving the shared pins while the bus master drives them.

Top module: `sram_tristate`

## Requirements
- R1: The array holds 2^ADDR_W words of DATA_W bits (8 x 4 by default). The binary value of `addr` picks the word, and each of the eight words keeps its own value independently.
- R2: While `cs_n`=0, `oe_n`=0 and `we_n`=1, the data pins carry the word at the current `addr`. The path is combinational, so a new address shows without any clock.
- R3: A write starts when `cs_n` and `we_n` are both 0. At that moment the value on the data input (`din` in split style, `dio` in shared style) is stored into the addressed word, and it can be read back afterwards.
- R4: Controls are active low. Pulsing `we_n` low while `cs_n` is 1 leaves every stored word unchanged.
- R5: The RAM drives the data pins only while `cs_n`=0, `oe_n`=0 and `we_n`=1. Otherwise they are high-impedance. In the shared style this holds even with `oe_n`=0 during a write, so a value driven onto `dio` from outside reads back unaltered.
- R6: With STYLE = PORT_SHARED, writes take data from `dio` and reads drive `dio`, with the same storage behaviour as the split style.
- R7: `addr` must stay constant while the internal write strobe (`cs_n`=0 and `we_n`=0) is active. A change during the strobe is flagged as a protocol violation.
- R8: A write strobe activates exactly one word-select line, so words other than the addressed one keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data (split style) |
| dout | output | DATA_W | Three-state read data (split style; high-impedance in shared style) |
| dio | inout | DATA_W | Bidirectional data bus (shared style; undriven in split style) |

## Verification
A fault in the decoder or in the strobe gating corrupts a neighbouring word or drops a write. The bench sees this on the first read-back of that word. Each full sweep writes every address and then reads every address in both port styles, with two complementary patterns. A fault in the drive gating shows straight away on the shared bus. A value the bench places on `dio` while the RAM should be silent reads back altered, in the same access in which the fault occurs.

// File: rtl/sram_pkg.sv
// Package: shared types for the static RAM block.
// Assumes: nothing beyond IEEE 1800-2017.
package sram_pkg;
    // Selects how the data pins are organised.
    typedef enum logic {
        PORT_SPLIT  = 1'b0,
        PORT_SHARED = 1'b1
    } port_style_e;
endpackage

// File: rtl/sram_ctl.sv
// Module: sram_ctl
// Turns the three active-low controls into an active-high write strobe
// and an output drive enable. The drive enable is held off while write
// enable is low, so a shared bus is never driven during a write.
// Assumes: controls are glitch-free level signals from the bus master.
module sram_ctl (
    input  logic cs_n,
    input  logic oe_n,
    input  logic we_n,
    output logic wr_stb,
    output logic drv_en
);
    // Write strobe: chip selected and write enabled.
    always_comb wr_stb = ~cs_n & ~we_n;

    // Output drive: selected, output enabled, not writing.
    always_comb drv_en = ~cs_n & ~oe_n & we_n;
endmodule

// File: rtl/sram_rowdec.sv
// Module: sram_rowdec
// Decodes the address into one read-select line per word. It also
// produces write-select lines, which are the read selects gated by the
// write strobe.
// Assumes: WORDS equals 2**ADDR_W.
module sram_rowdec #(
    parameter int ADDR_W = 3,
    localparam int WORDS = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_stb,
    output logic [WORDS-1:0]  rsel,
    output logic [WORDS-1:0]  wsel
);
    for (genvar i = 0; i < WORDS; i++) begin : g_row
        // Address match for word i.
        assign rsel[i] = (addr == ADDR_W'(i));
        // Write line for word i, active only inside the strobe.
        assign wsel[i] = rsel[i] & wr_stb;
    end
endmodule

// File: rtl/sram_array.sv
// Module: sram_array
// Storage of WORDS words. Each word captures wdata on the rising edge
// of its own write-select line. Read data is the OR of all words gated
// by their read selects.
// Assumes: at most one select line is high at a time; no reset of the
// contents (a static RAM powers up undefined).
module sram_array #(
    parameter int WORDS  = 8,
    parameter int DATA_W = 4
) (
    input  logic [WORDS-1:0]  wsel,
    input  logic [WORDS-1:0]  rsel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [WORDS*DATA_W-1:0] flat;

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        logic [DATA_W-1:0] word_q;
        // Latch the write data at the start of this word's write pulse.
        always_ff @(posedge wsel[i]) word_q <= wdata;
        assign flat[i*DATA_W +: DATA_W] = word_q;
    end

    // Combinational read: select the addressed word.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (rsel[i]) rdata = rdata | flat[i*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/sram_tristate.sv
// Module: sram_tristate (top)
// Static RAM with active-low controls and a three-state data port. STYLE
// picks separate din/dout pins or one bidirectional dio bus. The pins
// not used by the chosen style stay high-impedance.
// Assumes: addr is held during a write strobe; write data is valid
// before the strobe begins.
module sram_tristate
    import sram_pkg::*;
#(
    parameter int          ADDR_W = 3,
    parameter int          DATA_W = 4,
    parameter port_style_e STYLE  = PORT_SPLIT
) (
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    inout  wire  [DATA_W-1:0] dio
);
    localparam int WORDS = 1 << ADDR_W;

    logic              wr_stb;
    logic              drv_en;
    logic [WORDS-1:0]  rsel;
    logic [WORDS-1:0]  wsel;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rdata;

    sram_ctl u_ctl (
        .cs_n   (cs_n),
        .oe_n   (oe_n),
        .we_n   (we_n),
        .wr_stb (wr_stb),
        .drv_en (drv_en)
    );

    sram_rowdec #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (addr),
        .wr_stb (wr_stb),
        .rsel   (rsel),
        .wsel   (wsel)
    );

    sram_array #(.WORDS(WORDS), .DATA_W(DATA_W)) u_arr (
        .wsel   (wsel),
        .rsel   (rsel),
        .wdata  (wdata),
        .rdata  (rdata)
    );

    if (STYLE == PORT_SHARED) begin : g_shared
        // Shared bus: write data comes from, and read data goes to, dio.
        assign wdata = dio;
        assign dio   = drv_en ? rdata : {DATA_W{1'bz}};
        assign dout  = {DATA_W{1'bz}};
    end else begin : g_split
        // Separate pins: din feeds the array, dout is three-state.
        assign wdata = din;
        assign dout  = drv_en ? rdata : {DATA_W{1'bz}};
        assign dio   = {DATA_W{1'bz}};
    end
endmodule

// File: rtl/sram_tristate_chk.sv
// Module: sram_tristate_chk
// Protocol and structure checks for sram_tristate, bound to each instance.
// Assumes: an event-driven simulator; the checks use immediate assertions
// because the block has no clock.
module sram_tristate_chk #(
    parameter int ADDR_W = 3,
    parameter int WORDS  = 8
) (
    input logic              cs_n,
    input logic              oe_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_stb,
    input logic              drv_en,
    input logic [WORDS-1:0]  wsel
);
    // R5: the drive enable is on only under a read condition.
    always_comb begin
        if (cs_n !== 1'b0 || oe_n !== 1'b0 || we_n !== 1'b1)
            a_r5_drive_gated: assert (drv_en !== 1'b1);
    end

    // R5: no drive while a write strobe is active.
    always_comb begin
        a_r5_no_contention: assert (!(wr_stb === 1'b1 && drv_en === 1'b1));
    end

    // R8: at most one write line high, and exactly one inside a strobe.
    always_comb begin
        a_r8_onehot_wsel: assert ($onehot0(wsel));
        if (wr_stb === 1'b1)
            a_r8_one_word_written: assert ($countones(wsel) == 1);
    end

    // R7: the address may not move while the write strobe is active.
    always @(addr) begin
        a_r7_addr_held: assert (wr_stb !== 1'b1);
    end
endmodule

bind sram_tristate sram_tristate_chk #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_chk (
    .cs_n   (cs_n),
    .oe_n   (oe_n),
    .we_n   (we_n),
    .addr   (addr),
    .wr_stb (wr_stb),
    .drv_en (drv_en),
    .wsel   (wsel)
);

// File: tb/tb_sram_tristate.sv
`timescale 1ns/1ps
// Bench: sweeps all words through the split-port instance (dut) and the
// shared-bus instance (dut_bi) with two complementary patterns, then
// checks ignored writes and bus release.
module tb_sram_tristate;
    import sram_pkg::*;

    localparam int AW = 3;
    localparam int DW = 4;
    localparam int NW = 1 << AW;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz pacing clock

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    // Split-port instance.
    logic          s_cs_n = 1'b1, s_oe_n = 1'b1, s_we_n = 1'b1;
    logic [AW-1:0] s_addr = '0;
    logic [DW-1:0] s_din  = '0;
    logic [DW-1:0] s_dout;
    wire  [DW-1:0] s_dio;

    sram_tristate #(.ADDR_W(AW), .DATA_W(DW), .STYLE(PORT_SPLIT)) dut (
        .cs_n (s_cs_n), .oe_n (s_oe_n), .we_n (s_we_n),
        .addr (s_addr), .din (s_din), .dout (s_dout), .dio (s_dio)
    );

    // Shared-bus instance.
    logic          b_cs_n = 1'b1, b_oe_n = 1'b1, b_we_n = 1'b1;
    logic [AW-1:0] b_addr = '0;
    logic [DW-1:0] b_din  = '0;
    logic [DW-1:0] b_dout;
    logic          tb_drv = 1'b0;
    logic [DW-1:0] tb_val = '0;
    wire  [DW-1:0] b_dio;
    assign b_dio = tb_drv ? tb_val : {DW{1'bz}};

    sram_tristate #(.ADDR_W(AW), .DATA_W(DW), .STYLE(PORT_SHARED)) dut_bi (
        .cs_n (b_cs_n), .oe_n (b_oe_n), .we_n (b_we_n),
        .addr (b_addr), .din (b_din), .dout (b_dout), .dio (b_dio)
    );

    task automatic check(input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int a, input bit inv);
        logic [DW-1:0] v;
        v = DW'((a * 5 + 3) % 16);
        return inv ? ~v : v;
    endfunction

    // Split write: data set up first, strobe opened by cs_n.
    task automatic s_write(input int a, input logic [DW-1:0] d);
        s_addr = AW'(a); s_din = d; #1;
        s_we_n = 1'b0; #1;
        s_cs_n = 1'b0; #2;
        s_cs_n = 1'b1; #1;
        s_we_n = 1'b1; #1;
    endtask

    task automatic s_read(input int a, input logic [DW-1:0] exp, input string tag);
        s_addr = AW'(a); s_cs_n = 1'b0; s_oe_n = 1'b0; #2;
        check(tag, s_dout, exp);
        s_cs_n = 1'b1; s_oe_n = 1'b1; #1;
    endtask

    // Shared write: we_n goes low before cs_n, so the RAM never drives.
    task automatic b_write(input int a, input logic [DW-1:0] d, input logic oe);
        b_addr = AW'(a); tb_val = d; tb_drv = 1'b1; b_oe_n = oe; #1;
        b_we_n = 1'b0; #1;
        b_cs_n = 1'b0; #1;
        check("R5 shared bus during write", b_dio, d);
        #1;
        b_cs_n = 1'b1; #1;
        b_we_n = 1'b1; b_oe_n = 1'b1; #1;
        tb_drv = 1'b0; #1;
    endtask

    task automatic b_read(input int a, input logic [DW-1:0] exp, input string tag);
        b_addr = AW'(a); b_cs_n = 1'b0; b_oe_n = 1'b0; #2;
        check(tag, b_dio, exp);
        b_cs_n = 1'b1; b_oe_n = 1'b1; #1;
    endtask

    initial begin
        #5;
        // Idle state: shared bus released, external value reads back (R5).
        tb_val = 4'h9; tb_drv = 1'b1; #1;
        check("R5 idle bus released", b_dio, 4'h9);
        tb_drv = 1'b0; #1;

        // R1 R2 R3 R8: full sweeps with two complementary patterns.
        for (int p = 0; p < 2; p++) begin
            for (int a = 0; a < NW; a++) s_write(a, pat(a, p[0]));
            for (int a = 0; a < NW; a++) s_read(a, pat(a, p[0]), "R1 R3 R8 split readback");
            // R6: same sweep through the shared bus.
            for (int a = 0; a < NW; a++) b_write(a, pat(a, p[0]), 1'b1);
            for (int a = 0; a < NW; a++) b_read(a, pat(a, p[0]), "R6 shared readback");
        end

        // R2: combinational read, address stepped with controls held.
        s_cs_n = 1'b0; s_oe_n = 1'b0;
        for (int a = NW - 1; a >= 0; a--) begin
            s_addr = AW'(a); #1;
            check("R2 address follow", s_dout, pat(a, 1'b1));
        end
        s_cs_n = 1'b1; s_oe_n = 1'b1; #1;

        // R4: we_n pulsed with cs_n high changes nothing.
        s_addr = 3'd2; s_din = 4'h0; #1;
        s_we_n = 1'b0; #2; s_we_n = 1'b1; #1;
        s_read(2, pat(2, 1'b1), "R4 deselected write ignored");
        b_addr = 3'd6; tb_val = 4'h0; tb_drv = 1'b1; #1;
        b_we_n = 1'b0; #2; b_we_n = 1'b1; #1;
        tb_drv = 1'b0; #1;
        b_read(6, pat(6, 1'b1), "R4 shared deselected write ignored");

        // R5: write with oe_n low on the shared bus, then readback.
        b_write(5, 4'hC, 1'b0);
        b_read(5, 4'hC, "R5 write with oe low stored");
        b_read(4, pat(4, 1'b1), "R8 neighbour intact");

        // R5: selected but output disabled; bus stays with the bench.
        tb_val = 4'h6; tb_drv = 1'b1; b_addr = 3'd5; b_cs_n = 1'b0; #1;
        check("R5 oe high releases bus", b_dio, 4'h6);
        b_cs_n = 1'b1; b_oe_n = 1'b0; #1;
        check("R5 cs high releases bus", b_dio, 4'h6);
        b_oe_n = 1'b1; tb_drv = 1'b0; #1;

        // R7: write cycles above keep addr fixed inside the strobe.
        s_write(7, 4'h1);
        s_read(7, 4'h1, "R7 held-address write");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule